// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a one-bit signal by a programmable whole number of clock cycles. The signal first enters an input register. It then passes through a chain of shift-register stages whose lengths are 1, 2, 4 and so on up to 2^(CODE_W-1) cycles. Each stage either adds its length or is bypassed. A last one-cycle stage is used only by the force-maximum input. An output register ends the path.

A control word supplies the stage selects and one extra top bit. The word passes through a capture register. While `lock` is low, that register follows the word on every clock. While `lock` is high, it keeps its contents. Two override inputs act on the captured code without changing it: `force_min` bypasses every stage, and `force_max` engages every stage including the extra one. `force_min` wins when both are high. The captured top bit drives a complementary cascade output pair, so a second line can be chained behind this one. `blank` forces the output low.

Typical use is deskewing several channels against a reference channel. Several lines can be chained, with the cascade outputs of one driving the force inputs of the next.

Top module: `pdl_top`

## Requirements
- R1: After a cycle with `rst_n` low, `dout` is 0, `casc` is 0 and `casc_n` is 1.
- R2: With both force inputs low, a rising edge applied to `din` reaches `dout` after 2 + C clock cycles. C is the unsigned value of `ctrl[CODE_W-1:0]`, and bit k carries weight 2^k.
- R3: While `lock` is high, changes on `ctrl` alter neither the delay nor the cascade outputs.
- R4: While `lock` is low, `ctrl` is captured on each rising clock edge, and the new delay applies from the next cycle.
- R5: With `force_min` high, the delay is 2 cycles, whatever the code and whatever `force_max` is.
- R6: With `force_max` high and `force_min` low, the delay is 2 + 2^CODE_W cycles. That is one cycle more than the all-ones code.
- R7: The force inputs do not change the captured code. Once they are released, the captured code sets the delay again.
- R8: While `blank` is high, `dout` is 0 on the next cycle. A pulse entering the path during that time does not appear at the output.
- R9: `casc` equals the captured `ctrl[CODE_W]`, and `casc_n` is always its complement.
- R10: A pulse of width W cycles leaves the line with width W at any delay setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one delay unit is one period |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Signal to be delayed |
| ctrl | input | CODE_W+1 | Delay code in the low bits, cascade bit on top |
| lock | input | 1 | Low: the capture register follows `ctrl`; high: it holds |
| force_min | input | 1 | Bypass all stages (highest priority) |
| force_max | input | 1 | Engage all stages plus the extra unit |
| blank | input | 1 | High forces `dout` low |
| dout | output | 1 | Delayed signal |
| casc | output | 1 | Captured cascade bit |
| casc_n | output | 1 | Complement of `casc` |

## Verification
The bench runs a 4-bit code and sends a single-cycle pulse through every code value. It measures the arrival cycle and the width of the pulse at the output. A weight on the wrong bit, or a missing input or output register, therefore shows up as a wrong arrival cycle for specific codes. Further checks target the override corner cases:
- both force inputs high, where a wrong priority gives a delay of 18 instead of 2;
- force-maximum, where a missing extra stage gives 17 instead of 18;
- releasing the force inputs, where a design that overwrote the captured code would come back at the wrong delay.

The locked register is also tested: a new code and cascade bit are applied while `lock` is high and must be ignored. A blanked pulse must vanish completely.

// File: rtl/pdl_pkg.sv
// Shared helpers for the programmable delay line.
// Assumes stage weights are powers of two ordered from LSB upward.
package pdl_pkg;
    // Length in cycles of weighted stage k.
    function automatic int unsigned stage_weight(input int unsigned k);
        return 32'd1 << k;
    endfunction
endpackage

// File: rtl/pdl_ctrl.sv
// Control capture register: follows the control word while lock is low and
// holds it while lock is high. Assumes synchronous active-low reset.
module pdl_ctrl #(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic [CODE_W:0]   ctrl,
    output logic [CODE_W:0]   ctrl_q
);
    // Capture the control word on every clock unless locked.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (!lock) ctrl_q <= ctrl;
    end
endmodule

// File: rtl/pdl_sel.sv
// Override logic: turns the captured code and the force inputs into stage
// selects. force_min wins over force_max; neither alters the stored code.
module pdl_sel #(
    parameter int unsigned CODE_W = 10
) (
    input  logic [CODE_W-1:0] code_q,
    input  logic              force_min,
    input  logic              force_max,
    output logic [CODE_W-1:0] sel,
    output logic              sel_extra
);
    // Choose the stage selects by priority: min, then max, then code.
    always_comb begin
        if (force_min) begin
            sel       = '0;
            sel_extra = 1'b0;
        end else if (force_max) begin
            sel       = '1;
            sel_extra = 1'b1;
        end else begin
            sel       = code_q;
            sel_extra = 1'b0;
        end
    end
endmodule

// File: rtl/pdl_stage.sv
// One delay stage: a shift register of WEIGHT cycles and a bypass mux.
// The register always shifts, so it must be flushed before a select change
// if stale contents matter.
module pdl_stage #(
    parameter int unsigned WEIGHT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic x,
    output logic y
);
    logic [WEIGHT-1:0] sr;

    if (WEIGHT == 1) begin : g_one
        // Single-cycle delay register.
        always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= x;
        end
    end else begin : g_many
        // Multi-cycle shift register, input enters at bit 0.
        always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[WEIGHT-2:0], x};
        end
    end

    // Pick the delayed tap or pass straight through.
    assign y = sel ? sr[WEIGHT-1] : x;
endmodule

// File: rtl/pdl_top.sv
// Binary-weighted programmable delay line. Total latency is 2 + programmed
// delay cycles (input register, stage chain, output register).
// Assumes the code changes only while the path is idle.
module pdl_top #(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [CODE_W:0]   ctrl,
    input  logic              lock,
    input  logic              force_min,
    input  logic              force_max,
    input  logic              blank,
    output logic              dout,
    output logic              casc,
    output logic              casc_n
);
    localparam int unsigned NSTG = CODE_W + 1;

    logic [CODE_W:0]   ctrl_q;
    logic [CODE_W-1:0] sel;
    logic              sel_extra;
    logic              in_q;
    logic [NSTG:0]     chain;

    pdl_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .lock(lock), .ctrl(ctrl), .ctrl_q(ctrl_q)
    );

    pdl_sel #(.CODE_W(CODE_W)) u_sel (
        .code_q(ctrl_q[CODE_W-1:0]), .force_min(force_min),
        .force_max(force_max), .sel(sel), .sel_extra(sel_extra)
    );

    // Input register: first fixed cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= 1'b0;
        else        in_q <= din;
    end

    assign chain[0] = in_q;

    for (genvar k = 0; k < CODE_W; k++) begin : g_stage
        localparam int unsigned W = pdl_pkg::stage_weight(k);
        pdl_stage #(.WEIGHT(W)) u_stg (
            .clk(clk), .rst_n(rst_n), .sel(sel[k]),
            .x(chain[k]), .y(chain[k+1])
        );
    end

    pdl_stage #(.WEIGHT(1)) u_extra (
        .clk(clk), .rst_n(rst_n), .sel(sel_extra),
        .x(chain[CODE_W]), .y(chain[NSTG])
    );

    // Output register with blanking: second fixed cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= 1'b0;
        else        dout <= blank ? 1'b0 : chain[NSTG];
    end

    assign casc   = ctrl_q[CODE_W];
    assign casc_n = ~ctrl_q[CODE_W];
endmodule

// File: rtl/pdl_chk.sv
// Property checker for pdl_top, attached by bind below.
module pdl_chk #(
    parameter int unsigned CODE_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CODE_W:0] ctrl,
    input logic            lock,
    input logic            force_min,
    input logic            blank,
    input logic            in_q,
    input logic            dout,
    input logic            casc,
    input logic            casc_n
);
    p_casc_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        casc != casc_n);

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> casc == $past(ctrl[CODE_W]));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(casc));

    p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> !dout);

    p_min_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_min && !blank) |=> dout == $past(in_q));
endmodule

bind pdl_top pdl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .lock(lock),
    .force_min(force_min), .blank(blank), .in_q(in_q),
    .dout(dout), .casc(casc), .casc_n(casc_n)
);

// File: tb/sim_pdl_top.sv
// Bench for pdl_top with a 4-bit code: sweeps all codes and the override,
// lock, blank and cascade corner cases.
module sim_pdl_top;
    localparam int CLK_PER = 10;
    localparam int CW      = 4;
    localparam int FLUSH   = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          din = 1'b0;
    logic [CW:0]   ctrl = '0;
    logic          lock = 1'b0;
    logic          force_min = 1'b0;
    logic          force_max = 1'b0;
    logic          blank = 1'b0;
    logic          dout, casc, casc_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    pdl_top #(.CODE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .ctrl(ctrl), .lock(lock),
        .force_min(force_min), .force_max(force_max), .blank(blank),
        .dout(dout), .casc(casc), .casc_n(casc_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Send a pulse of width w; report first-high index and number of highs.
    task automatic pulse(input int w, output int lat, output int hi);
        lat = -1;
        hi  = 0;
        @(negedge clk);
        din = 1'b1;
        for (int j = 1; j <= FLUSH; j++) begin
            @(negedge clk);
            if (j == w) din = 1'b0;
            if (dout) begin
                hi++;
                if (lat < 0) lat = j;
            end
        end
    endtask

    task automatic load(input logic [CW:0] v);
        @(negedge clk);
        lock = 1'b0;
        ctrl = v;
        @(negedge clk);
        lock = 1'b1;
    endtask

    initial begin
        int lat, hi;
        repeat (3) @(negedge clk);
        chk(dout == 1'b0, "R1 dout", dout, 0);
        chk(casc == 1'b0, "R1 casc", casc, 0);
        chk(casc_n == 1'b1, "R1 casc_n", casc_n, 1);
        rst_n = 1'b1;

        // R2 / R10: sweep every code with a single-cycle pulse.
        for (int c = 0; c < (1 << CW); c++) begin
            load(c[CW:0]);
            pulse(1, lat, hi);
            chk(lat == 2 + c, "R2 latency", lat, 2 + c);
            chk(hi == 1, "R10 width", hi, 1);
        end

        // R10: wider pulse keeps its width.
        load(5'd6);
        pulse(3, lat, hi);
        chk(lat == 8, "R2 latency w3", lat, 8);
        chk(hi == 3, "R10 width3", hi, 3);

        // R3: locked register ignores new code and cascade bit.
        load(5'd3);
        @(negedge clk);
        ctrl = 5'b1_1001;
        pulse(1, lat, hi);
        chk(lat == 5, "R3 delay held", lat, 5);
        chk(casc == 1'b0, "R3 casc held", casc, 0);

        // R4 / R9: unlock, captured after one edge.
        @(negedge clk);
        lock = 1'b0;
        @(negedge clk);
        lock = 1'b1;
        chk(casc == 1'b1, "R9 casc", casc, 1);
        chk(casc_n == 1'b0, "R9 casc_n", casc_n, 0);
        pulse(1, lat, hi);
        chk(lat == 11, "R4 new delay", lat, 11);

        // R6: force maximum.
        load(5'd2);
        force_max = 1'b1;
        pulse(1, lat, hi);
        chk(lat == 2 + (1 << CW), "R6 max", lat, 2 + (1 << CW));

        // R5: force minimum wins over maximum and the code.
        force_min = 1'b1;
        pulse(1, lat, hi);
        chk(lat == 2, "R5 min priority", lat, 2);
        force_max = 1'b0;
        pulse(1, lat, hi);
        chk(lat == 2, "R5 min", lat, 2);

        // R7: released, stored code returns.
        force_min = 1'b0;
        pulse(1, lat, hi);
        chk(lat == 4, "R7 restored", lat, 4);

        // R8: blank suppresses the pulse.
        blank = 1'b1;
        pulse(1, lat, hi);
        chk(hi == 0, "R8 blank", hi, 0);
        blank = 1'b0;
        pulse(1, lat, hi);
        chk(lat == 4, "R8 unblank", lat, 4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule